// File: doc/BRIEF.md
# CPU Space Cycle Responder

This block sits as a slave on an asynchronous processor bus and answers the special cycles that the processor runs in its CPU address space. It samples the function code lines, the address strobe, both data strobes and the read/write line through a synchroniser. A cycle counts as CPU space when all three function code lines are high while the address strobe is low. Four address bits (bus bits 19 down to 16) give the cycle kind, and three address bits (bus bits 3 down to 1) give the interrupt level being acknowledged.

When an interrupt acknowledge carries the level of the local requester, the block answers in one of two ways. In vectored mode it drives a supplied vector byte on the low data byte and then pulls the transfer acknowledge low. In autovector mode it pulls the autovector request low and drives no data. The answer is held until the address strobe goes high again. A breakpoint acknowledge is reported on a one-cycle pulse and gets no answer. Every other kind is reserved: the block flags it on another pulse and stays silent. The upper data byte is never driven.

Nothing streams through this block. All pins are plain control and status lines, so there is no valid/ready handshake and no back-pressure. Bus timing is set by the strobes alone.

Top module: `cpu_space_responder`

## Requirements
- R1: A cycle is decoded only when func_code equals 3'b111 while addr_strobe_n is low. With any other function code the block gives no answer and no pulse.
- R2: addr_type equal to 4'b1111 marks an interrupt acknowledge. The block answers only when req_level is non-zero and equals addr_level. Any other level gets no answer.
- R3: With use_autovec low, a matching interrupt acknowledge drives vector_byte on data_out, sets data_oe high and pulls ack_n low. auto_ack_n stays high.
- R4: With use_autovec high, a matching interrupt acknowledge pulls auto_ack_n low. ack_n stays high and data_oe stays low.
- R5: ack_n and auto_ack_n are never low in the same cycle.
- R6: data_oe rises at least one clock before ack_n falls. data_oe stays high and data_out stays stable for as long as ack_n is low.
- R7: The answer waits until a data strobe (upper_strobe_n or lower_strobe_n) is low with rd_wr high. A matching cycle with no strobe, or with rd_wr low, gets no answer.
- R8: Once addr_strobe_n has been high for SYNC_STAGES+2 clocks, ack_n and auto_ack_n are high and data_oe is low.
- R9: addr_type equal to 4'b0000 in a CPU space cycle raises bkpt_pulse for exactly one clock and gets no answer.
- R10: Any other addr_type in a CPU space cycle raises rsvd_pulse for exactly one clock and gets no answer.
- R11: After reset, ack_n and auto_ack_n are high, data_oe, bkpt_pulse and rsvd_pulse are low, and data_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_code | input | 3 | Bus function code lines |
| addr_strobe_n | input | 1 | Bus address strobe, active low |
| upper_strobe_n | input | 1 | Upper data strobe, active low |
| lower_strobe_n | input | 1 | Lower data strobe, active low |
| rd_wr | input | 1 | High for a read cycle |
| addr_type | input | 4 | Bus address bits 19..16, the CPU space kind |
| addr_level | input | LVL_W | Bus address bits 3..1, the acknowledged level |
| req_level | input | LVL_W | Level of the local requester, 0 for none |
| use_autovec | input | 1 | 1 selects autovector reply, 0 selects vector byte |
| vector_byte | input | VEC_W | Vector returned in vectored mode |
| ack_n | output | 1 | Transfer acknowledge, active low |
| auto_ack_n | output | 1 | Autovector request, active low |
| data_out | output | VEC_W | Value for data bus bits 7..0 |
| data_oe | output | 1 | Drive enable for data bus bits 7..0 |
| bkpt_pulse | output | 1 | One-clock breakpoint acknowledge flag |
| rsvd_pulse | output | 1 | One-clock reserved kind flag |

## Verification
The assertions check on every clock that the two acknowledges never overlap, that the data enable comes before the transfer acknowledge and covers it with a stable byte, that no data is driven during an autovector reply, that every reply is released within the set delay after the address strobe goes high, and that each pulse lasts a single clock. Only the bench scenarios can show that the decoding is right. Those scenarios check which kind and level combinations get which reply, that other function codes and write cycles are ignored, that a reply waits for a data strobe, and that the returned byte is the supplied vector. The bench sweeps all sixteen kinds and every pair of bus level and requester level in both modes.

// File: rtl/cs_resp_pkg.sv
package cs_resp_pkg;

  typedef enum logic [1:0] {
    K_IACK_HIT,
    K_IACK_MISS,
    K_BKPT,
    K_RSVD
  } cs_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_DRIVE,
    ST_ACK,
    ST_AUTO,
    ST_DONE
  } rsp_state_e;

  localparam logic [3:0] TYPE_IACK = 4'hF;
  localparam logic [3:0] TYPE_BKPT = 4'h0;
  localparam logic [2:0] FC_CPU    = 3'b111;

endpackage

// File: rtl/cs_bus_sync.sv
module cs_bus_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_flops
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
          stg[0] <= d;
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cs_classify.sv
module cs_classify
  import cs_resp_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic [2:0]       fc,
  input  logic             as_n,
  input  logic [3:0]       type_f,
  input  logic [LVL_W-1:0] bus_lvl,
  input  logic [LVL_W-1:0] req_lvl,
  output logic             cs_start,
  output cs_kind_e         kind
);

  logic lvl_match;

  assign cs_start  = (fc == FC_CPU) && !as_n;
  assign lvl_match = (req_lvl != '0) && (bus_lvl == req_lvl);

  always_comb begin
    if (type_f == TYPE_IACK) begin
      kind = lvl_match ? K_IACK_HIT : K_IACK_MISS;
    end else if (type_f == TYPE_BKPT) begin
      kind = K_BKPT;
    end else begin
      kind = K_RSVD;
    end
  end

endmodule

// File: rtl/cs_rsp_fsm.sv
module cs_rsp_fsm
  import cs_resp_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_start,
  input  cs_kind_e         kind,
  input  logic             as_n,
  input  logic             ds_any,
  input  logic             rd,
  input  logic             use_auto,
  input  logic [VEC_W-1:0] vector,
  output logic             ack_n,
  output logic             auto_n,
  output logic [VEC_W-1:0] data_q,
  output logic             oe,
  output logic             bkpt_p,
  output logic             rsvd_p
);

  rsp_state_e state_q, state_d;
  logic       take;

  assign take = (state_q == ST_IDLE) && cs_start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cs_start) begin
          state_d = (kind == K_IACK_HIT) ? ST_ARMED : ST_DONE;
        end
      end
      ST_ARMED: begin
        if (as_n) begin
          state_d = ST_IDLE;
        end else if (ds_any && rd) begin
          state_d = use_auto ? ST_AUTO : ST_DRIVE;
        end
      end
      ST_DRIVE: begin
        state_d = as_n ? ST_IDLE : ST_ACK;
      end
      ST_ACK, ST_AUTO, ST_DONE: begin
        if (as_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_n   <= 1'b1;
      auto_n  <= 1'b1;
      oe      <= 1'b0;
      data_q  <= '0;
      bkpt_p  <= 1'b0;
      rsvd_p  <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_n   <= !(state_d == ST_ACK);
      auto_n  <= !(state_d == ST_AUTO);
      oe      <= (state_d == ST_DRIVE) || (state_d == ST_ACK);
      bkpt_p  <= take && (kind == K_BKPT);
      rsvd_p  <= take && (kind == K_RSVD);
      if (state_q == ST_ARMED && state_d == ST_DRIVE) begin
        data_q <= vector;
      end else if (state_d == ST_IDLE) begin
        data_q <= '0;
      end
    end
  end

endmodule

// File: rtl/cpu_space_responder.sv
module cpu_space_responder
  import cs_resp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = 3,
  parameter int VEC_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       func_code,
  input  logic             addr_strobe_n,
  input  logic             upper_strobe_n,
  input  logic             lower_strobe_n,
  input  logic             rd_wr,
  input  logic [3:0]       addr_type,
  input  logic [LVL_W-1:0] addr_level,
  input  logic [LVL_W-1:0] req_level,
  input  logic             use_autovec,
  input  logic [VEC_W-1:0] vector_byte,
  output logic             ack_n,
  output logic             auto_ack_n,
  output logic [VEC_W-1:0] data_out,
  output logic             data_oe,
  output logic             bkpt_pulse,
  output logic             rsvd_pulse
);

  localparam int BUS_W = 7;
  localparam logic [BUS_W-1:0] BUS_IDLE = 7'b000_1_1_1_1;

  logic [BUS_W-1:0] bus_raw, bus_s;
  logic [2:0]       fc_s;
  logic             as_s_n, uds_s_n, lds_s_n, rw_s;
  logic             cs_start;
  cs_kind_e         kind;

  assign bus_raw = {func_code, addr_strobe_n, upper_strobe_n, lower_strobe_n, rd_wr};
  assign {fc_s, as_s_n, uds_s_n, lds_s_n, rw_s} = bus_s;

  cs_bus_sync #(
    .W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  cs_classify #(.LVL_W(LVL_W)) u_class (
    .fc(fc_s), .as_n(as_s_n), .type_f(addr_type), .bus_lvl(addr_level),
    .req_lvl(req_level), .cs_start(cs_start), .kind(kind)
  );

  cs_rsp_fsm #(.VEC_W(VEC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .kind(kind),
    .as_n(as_s_n), .ds_any(!uds_s_n || !lds_s_n), .rd(rw_s),
    .use_auto(use_autovec), .vector(vector_byte),
    .ack_n(ack_n), .auto_n(auto_ack_n), .data_q(data_out), .oe(data_oe),
    .bkpt_p(bkpt_pulse), .rsvd_p(rsvd_pulse)
  );

endmodule

// File: rtl/cpu_space_responder_chk.sv
module cpu_space_responder_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_strobe_n,
  input logic             ack_n,
  input logic             auto_ack_n,
  input logic [VEC_W-1:0] data_out,
  input logic             data_oe,
  input logic             bkpt_pulse,
  input logic             rsvd_pulse
);

  localparam int LIMIT = SYNC_STAGES + 2;
  localparam int CW    = $clog2(LIMIT + 1) + 1;

  logic [CW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) high_cnt <= '0;
    else if (!addr_strobe_n) high_cnt <= '0;
    else if (high_cnt < CW'(LIMIT)) high_cnt <= high_cnt + 1'b1;
  end

  a_r5_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ack_n && !auto_ack_n));

  a_r6_bus_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && $past(ack_n)) |-> $past(data_oe));

  a_r6_oe_covers_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> data_oe);

  a_r6_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !$past(ack_n)) |-> $stable(data_out));

  a_r4_no_drive_auto: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_ack_n |-> !data_oe);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (high_cnt >= CW'(LIMIT)) |-> (ack_n && auto_ack_n && !data_oe));

  a_r9_bkpt_single: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_pulse |=> !bkpt_pulse);

  a_r10_rsvd_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_pulse |=> !rsvd_pulse);

  a_r10_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(bkpt_pulse && rsvd_pulse));

endmodule

bind cpu_space_responder cpu_space_responder_chk #(
  .SYNC_STAGES(SYNC_STAGES), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_strobe_n(addr_strobe_n), .ack_n(ack_n),
  .auto_ack_n(auto_ack_n), .data_out(data_out), .data_oe(data_oe),
  .bkpt_pulse(bkpt_pulse), .rsvd_pulse(rsvd_pulse)
);

// File: tb/test_cpu_space_responder.sv
module test_cpu_space_responder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] func_code = 3'b000;
  logic       addr_strobe_n = 1'b1;
  logic       upper_strobe_n = 1'b1;
  logic       lower_strobe_n = 1'b1;
  logic       rd_wr = 1'b1;
  logic [3:0] addr_type = 4'h0;
  logic [2:0] addr_level = 3'd0;
  logic [2:0] req_level = 3'd0;
  logic       use_autovec = 1'b0;
  logic [7:0] vector_byte = 8'h00;
  logic       ack_n, auto_ack_n, data_oe, bkpt_pulse, rsvd_pulse;
  logic [7:0] data_out;

  int checks = 0;
  int errors = 0;
  int bk_cnt = 0;
  int rs_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpu_space_responder i_cpu_space_responder (
    .clk(clk), .rst_n(rst_n), .func_code(func_code),
    .addr_strobe_n(addr_strobe_n), .upper_strobe_n(upper_strobe_n),
    .lower_strobe_n(lower_strobe_n), .rd_wr(rd_wr), .addr_type(addr_type),
    .addr_level(addr_level), .req_level(req_level), .use_autovec(use_autovec),
    .vector_byte(vector_byte), .ack_n(ack_n), .auto_ack_n(auto_ack_n),
    .data_out(data_out), .data_oe(data_oe), .bkpt_pulse(bkpt_pulse),
    .rsvd_pulse(rsvd_pulse)
  );

  always @(posedge clk) begin
    if (bkpt_pulse) bk_cnt <= bk_cnt + 1;
    if (rsvd_pulse) rs_cnt <= rs_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic txn(input string tag, input logic [2:0] fc, input logic [3:0] ty,
                     input logic [2:0] lvl, input logic [2:0] req, input logic av,
                     input logic rw, input logic strobe);
    logic [7:0] vec;
    bit   cs, hit, resp, exp_ack, exp_auto, exp_bk, exp_rs;
    int   bk0, rs0;
    vec      = {ty, lvl, req[0]} ^ 8'h5A;
    cs       = (fc == 3'b111);
    hit      = cs && (ty == 4'hF) && (req != 0) && (lvl == req);
    resp     = hit && rw && strobe;
    exp_ack  = resp && !av;
    exp_auto = resp && av;
    exp_bk   = cs && (ty == 4'h0);
    exp_rs   = cs && (ty != 4'h0) && (ty != 4'hF);
    @(negedge clk);
    bk0 = bk_cnt;
    rs0 = rs_cnt;
    func_code = fc; addr_type = ty; addr_level = lvl; req_level = req;
    use_autovec = av; rd_wr = rw; vector_byte = vec;
    addr_strobe_n = 1'b0;
    repeat (3) @(negedge clk);
    if (strobe) begin
      upper_strobe_n = 1'b0;
      lower_strobe_n = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk(tag, {31'd0, ack_n}, {31'd0, !exp_ack});
    chk(tag, {31'd0, auto_ack_n}, {31'd0, !exp_auto});
    chk("R6", {31'd0, data_oe}, {31'd0, exp_ack});
    if (exp_ack) chk("R3", {24'd0, data_out}, {24'd0, vec});
    chk("R5", {31'd0, (!ack_n && !auto_ack_n)}, 32'd0);
    addr_strobe_n = 1'b1; upper_strobe_n = 1'b1; lower_strobe_n = 1'b1;
    func_code = 3'b000;
    repeat (6) @(negedge clk);
    chk("R8", {29'd0, ack_n, auto_ack_n, data_oe}, 32'b110);
    chk("R9", bk_cnt - bk0, {31'd0, exp_bk});
    chk("R10", rs_cnt - rs0, {31'd0, exp_rs});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", {29'd0, ack_n, auto_ack_n, data_oe}, 32'b110);
    chk("R11", {22'd0, bkpt_pulse, rsvd_pulse, data_out}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9 R10: every kind code, level matched, both reply modes
    for (int t = 0; t < 16; t++) begin
      for (int m = 0; m < 2; m++) begin
        txn((m == 0) ? "R3" : "R4", 3'b111, 4'(t), 3'd3, 3'd3, 1'(m), 1'b1, 1'b1);
      end
    end
    // R2: every bus level against every requester level
    for (int l = 0; l < 8; l++) begin
      for (int q = 0; q < 8; q++) begin
        for (int m = 0; m < 2; m++) begin
          txn("R2", 3'b111, 4'hF, 3'(l), 3'(q), 1'(m), 1'b1, 1'b1);
        end
      end
    end
    // R1: non-CPU function codes with an otherwise matching acknowledge
    for (int f = 0; f < 7; f++) begin
      txn("R1", 3'(f), 4'hF, 3'd5, 3'd5, 1'b0, 1'b1, 1'b1);
      txn("R1", 3'(f), 4'h0, 3'd5, 3'd5, 1'b0, 1'b1, 1'b1);
    end
    // R7: no data strobe, and write direction
    for (int m = 0; m < 2; m++) begin
      txn("R7", 3'b111, 4'hF, 3'd7, 3'd7, 1'(m), 1'b1, 1'b0);
      txn("R7", 3'b111, 4'hF, 3'd7, 3'd7, 1'(m), 1'b0, 1'b1);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule